// File: doc/BRIEF.md
# Event Context Save/Restore Sequencer

This block moves processor context between the core and a system stack in memory when an event handler is entered and when it is left. When an event is accepted, it stores the status word and the return address on the stack. For the four interrupt levels it also stores six general registers. It then gives the core a new status word, with the mode and mask bits set for the event, and loads the program counter with that event's own handler address. When the core issues an event-return command, the block reads the same words back in the opposite order and restores them.

The core supplies the stack pointer, status word and program counter as inputs. Updates come back as one-cycle write strobes. The general registers are reached through one asynchronous read port and one write port of a small register array. Memory is reached through a single-word request/acknowledge port. Choosing which event to accept is left to other logic, which only presents the event code together with a start pulse.

Top module: `evt_ctx_seq`

## Requirements
- R1: After reset, `busy`, `mem_req`, `rf_we`, `sr_we`, `pc_we` and `sp_we` are all low.
- R2: On entry, the block writes 8 words for event codes 0 to 3 (interrupt levels 0 to 3) and 2 words for codes 4 to 7. The stack grows downward: word k goes to address `sp_in - 4*(k+1)`, and no word below the last one is written.
- R3: The entry push order is: status word (the value before any update), return PC, register 14 (link), then registers 12, 11, 10, 9, 8.
- R4: At the end of entry, the PC is written with `HANDLER_BASE + code*HANDLER_STRIDE`.
- R5: At the end of entry, the status word is rewritten and all other bits are kept, using this field layout: mode field bits [2:0], level masks bits [6:3] (bit 3+n masks level n), fault mask bit 7, global mask bit 8. The mode becomes code+2 for levels 0-3, 6 for code 4 and 7 for codes 5-7. Level n sets masks 0..n. Code 4 sets all four level masks and bit 8. Codes 5-7 set all four level masks, bit 7 and bit 8.
- R6: The stack pointer is written with the final address: `sp_in - 4*words` after entry and `sp_in + 4*words` after return.
- R7: On return, words are read from `sp_in`, `sp_in+4` and so on. The count is 8 if the current status mode field is 2 to 5 (an interrupt level) and 2 otherwise.
- R8: Return restores in the reverse of the push order: registers 8, 9, 10, 11, 12, 14, then PC, then status word. A register is written in the same cycle its word is acknowledged.
- R9: `busy` rises in the cycle after an accepted start and stays high until the transfer ends. Start commands seen while busy are ignored.
- R10: A memory request is held, with unchanged address and direction, until `mem_ack`. Each acknowledge moves exactly one word.
- R11: If `evt_start` and `ret_start` arrive together while idle, entry is performed.
- R12: `sr_we`, `pc_we` and `sp_we` pulse together for exactly one cycle, after the last word and with no request active. `busy` falls in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_start | input | 1 | Start entry for the event in `evt_code` |
| evt_code | input | 3 | Accepted event: 0-3 interrupt levels, 4 non-maskable, 5-7 faults |
| ret_start | input | 1 | Start event return |
| busy | output | 1 | Transfer in progress |
| sp_in | input | DW | Current stack pointer |
| sr_in | input | DW | Current status word |
| pc_in | input | DW | Return address for entry |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_wdata | output | DW | New stack pointer |
| sr_we | output | 1 | Status word write strobe |
| sr_wdata | output | DW | New status word |
| pc_we | output | 1 | PC write strobe |
| pc_wdata | output | DW | New PC |
| rf_raddr | output | 4 | Register read address |
| rf_rdata | input | DW | Register read data (asynchronous) |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | 4 | Register write address |
| rf_wdata | output | DW | Register write data |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = write (push), 0 = read (pop) |
| mem_addr | output | DW | Byte address of the word |
| mem_wdata | output | DW | Word to store |
| mem_ack | input | 1 | Memory acknowledge, one cycle per word |
| mem_rdata | input | DW | Read word, valid with `mem_ack` |

## Verification
All eight event codes are swept against four status words. These include one with mask bits already set and one with all upper bits set, so that mask setting is told apart from mask preservation. Interrupt codes are told apart from the others by checking the eight-word and two-word stack images, and which registers get restored after the bench overwrites them. The memory model stretches its acknowledge over zero to two wait cycles, which exposes any request that is dropped or moves early. Extra start pulses given mid-transfer, and starts given together with a return, separate the ignore rule and the entry-over-return rule from normal operation.

// File: rtl/evt_ctx_pkg.sv
package evt_ctx_pkg;

    localparam int CODE_W    = 3;
    localparam int MODE_W    = 3;
    localparam int LVL_MASK0 = 3;
    localparam int FAULT_MSK = 7;
    localparam int GLOB_MSK  = 8;
    localparam int NUM_LVL   = 4;
    localparam int MAX_WORDS = 8;
    localparam int CORE_WORDS = 2;
    localparam int REG_AW    = 4;
    localparam int POS_W     = $clog2(MAX_WORDS);
    localparam logic [REG_AW-1:0] LINK_IDX = 4'd14;

    typedef enum logic [1:0] {ITEM_SR, ITEM_PC, ITEM_GPR} item_kind_e;

    typedef struct packed {
        item_kind_e        kind;
        logic [REG_AW-1:0] reg_idx;
    } item_t;

    typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_POP, ST_FIN} seq_state_e;

    function automatic logic is_level_code(input logic [CODE_W-1:0] code);
        return code < CODE_W'(NUM_LVL);
    endfunction

    function automatic logic [MODE_W-1:0] mode_for(input logic [CODE_W-1:0] code);
        if (is_level_code(code)) return MODE_W'(code + 3'd2);
        else if (code == 3'd4)   return 3'd6;
        else                     return 3'd7;
    endfunction

    function automatic logic is_level_mode(input logic [MODE_W-1:0] mode);
        return (mode >= 3'd2) && (mode <= 3'd5);
    endfunction

    // Push slot k holds this item; pop walks the slots backwards.
    function automatic item_t item_at(input int pos);
        item_t it;
        case (pos)
            0:       it = '{kind: ITEM_SR,  reg_idx: '0};
            1:       it = '{kind: ITEM_PC,  reg_idx: '0};
            2:       it = '{kind: ITEM_GPR, reg_idx: LINK_IDX};
            default: it = '{kind: ITEM_GPR, reg_idx: REG_AW'(15 - pos)};
        endcase
        return it;
    endfunction

endpackage

// File: rtl/evt_ctx_order.sv
module evt_ctx_order
    import evt_ctx_pkg::*;
(
    input  logic [POS_W-1:0] pos,
    output item_t            item
);
    item_t slot_tbl [MAX_WORDS];

    for (genvar gi = 0; gi < MAX_WORDS; gi++) begin : g_slot
        assign slot_tbl[gi] = item_at(gi);
    end

    assign item = slot_tbl[pos];
endmodule

// File: rtl/evt_ctx_entry.sv
module evt_ctx_entry
    import evt_ctx_pkg::*;
#(
    parameter int              DW             = 32,
    parameter logic [DW-1:0]   HANDLER_BASE   = 32'h0000_4000,
    parameter logic [DW-1:0]   HANDLER_STRIDE = 32'h0000_0080
) (
    input  logic [DW-1:0]     sr_old,
    input  logic [CODE_W-1:0] code,
    output logic [DW-1:0]     sr_new,
    output logic [DW-1:0]     handler_pc
);
    always_comb begin
        sr_new = sr_old;
        sr_new[MODE_W-1:0] = mode_for(code);
        for (int i = 0; i < NUM_LVL; i++) begin
            if (!is_level_code(code) || (CODE_W'(i) <= code))
                sr_new[LVL_MASK0 + i] = 1'b1;
        end
        if (!is_level_code(code)) sr_new[GLOB_MSK] = 1'b1;
        if (code > 3'd4)          sr_new[FAULT_MSK] = 1'b1;
    end

    assign handler_pc = HANDLER_BASE + DW'(code) * HANDLER_STRIDE;
endmodule

// File: rtl/evt_ctx_fsm.sv
module evt_ctx_fsm
    import evt_ctx_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_start,
    input  logic [CODE_W-1:0] evt_code,
    input  logic              ret_start,
    input  logic [DW-1:0]     sp_in,
    input  logic [DW-1:0]     sr_in,
    input  logic [DW-1:0]     pc_in,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    input  logic [DW-1:0]     rf_rdata,
    input  item_t             cur_item,
    input  logic [DW-1:0]     entry_sr,
    input  logic [DW-1:0]     entry_pc,
    output logic [POS_W-1:0]  pos,
    output logic [CODE_W-1:0] code_q,
    output logic [DW-1:0]     sr_q,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic [REG_AW-1:0] rf_raddr,
    output logic              rf_we,
    output logic [REG_AW-1:0] rf_waddr,
    output logic [DW-1:0]     rf_wdata,
    output logic              sp_we,
    output logic [DW-1:0]     sp_wdata,
    output logic              sr_we,
    output logic [DW-1:0]     sr_wdata,
    output logic              pc_we,
    output logic [DW-1:0]     pc_wdata
);
    localparam logic [DW-1:0]    WSTEP     = DW'(DW / 8);
    localparam logic [POS_W-1:0] LAST_LONG  = POS_W'(MAX_WORDS - 1);
    localparam logic [POS_W-1:0] LAST_SHORT = POS_W'(CORE_WORDS - 1);

    seq_state_e       state;
    logic [POS_W-1:0] cnt;
    logic [POS_W-1:0] last_idx;
    logic             pop_q;
    logic [DW-1:0]    addr_q;
    logic [DW-1:0]    pc_q;
    logic             last_word;

    assign last_word = (cnt == last_idx);
    assign pos       = (state == ST_POP) ? (last_idx - cnt) : cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            last_idx <= '0;
            pop_q    <= 1'b0;
            code_q   <= '0;
            addr_q   <= '0;
            sr_q     <= '0;
            pc_q     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (evt_start) begin
                        state    <= ST_PUSH;
                        pop_q    <= 1'b0;
                        code_q   <= evt_code;
                        last_idx <= is_level_code(evt_code) ? LAST_LONG : LAST_SHORT;
                        addr_q   <= sp_in;
                        sr_q     <= sr_in;
                        pc_q     <= pc_in;
                    end else if (ret_start) begin
                        state    <= ST_POP;
                        pop_q    <= 1'b1;
                        last_idx <= is_level_mode(sr_in[MODE_W-1:0]) ? LAST_LONG : LAST_SHORT;
                        addr_q   <= sp_in;
                    end
                end
                ST_PUSH: begin
                    if (mem_ack) begin
                        addr_q <= addr_q - WSTEP;
                        cnt    <= cnt + 1'b1;
                        if (last_word) state <= ST_FIN;
                    end
                end
                ST_POP: begin
                    if (mem_ack) begin
                        addr_q <= addr_q + WSTEP;
                        cnt    <= cnt + 1'b1;
                        if (cur_item.kind == ITEM_SR) sr_q <= mem_rdata;
                        if (cur_item.kind == ITEM_PC) pc_q <= mem_rdata;
                        if (last_word) state <= ST_FIN;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy     = (state != ST_IDLE);
        mem_req  = (state == ST_PUSH) || (state == ST_POP);
        mem_we   = (state == ST_PUSH);
        mem_addr = (state == ST_PUSH) ? (addr_q - WSTEP) : addr_q;
        case (cur_item.kind)
            ITEM_SR: mem_wdata = sr_q;
            ITEM_PC: mem_wdata = pc_q;
            default: mem_wdata = rf_rdata;
        endcase
        rf_raddr = cur_item.reg_idx;
        rf_we    = (state == ST_POP) && mem_ack && (cur_item.kind == ITEM_GPR);
        rf_waddr = cur_item.reg_idx;
        rf_wdata = mem_rdata;
        sp_we    = (state == ST_FIN);
        sr_we    = (state == ST_FIN);
        pc_we    = (state == ST_FIN);
        sp_wdata = addr_q;
        sr_wdata = pop_q ? sr_q : entry_sr;
        pc_wdata = pop_q ? pc_q : entry_pc;
    end
endmodule

// File: rtl/evt_ctx_seq.sv
module evt_ctx_seq
    import evt_ctx_pkg::*;
#(
    parameter int            DW             = 32,
    parameter logic [DW-1:0] HANDLER_BASE   = 32'h0000_4000,
    parameter logic [DW-1:0] HANDLER_STRIDE = 32'h0000_0080
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_start,
    input  logic [2:0]        evt_code,
    input  logic              ret_start,
    output logic              busy,
    input  logic [DW-1:0]     sp_in,
    input  logic [DW-1:0]     sr_in,
    input  logic [DW-1:0]     pc_in,
    output logic              sp_we,
    output logic [DW-1:0]     sp_wdata,
    output logic              sr_we,
    output logic [DW-1:0]     sr_wdata,
    output logic              pc_we,
    output logic [DW-1:0]     pc_wdata,
    output logic [3:0]        rf_raddr,
    input  logic [DW-1:0]     rf_rdata,
    output logic              rf_we,
    output logic [3:0]        rf_waddr,
    output logic [DW-1:0]     rf_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata
);
    logic [POS_W-1:0]  pos;
    item_t             cur_item;
    logic [CODE_W-1:0] code_q;
    logic [DW-1:0]     sr_q;
    logic [DW-1:0]     entry_sr;
    logic [DW-1:0]     entry_pc;

    evt_ctx_order u_order (
        .pos  (pos),
        .item (cur_item)
    );

    evt_ctx_entry #(
        .DW             (DW),
        .HANDLER_BASE   (HANDLER_BASE),
        .HANDLER_STRIDE (HANDLER_STRIDE)
    ) u_entry (
        .sr_old     (sr_q),
        .code       (code_q),
        .sr_new     (entry_sr),
        .handler_pc (entry_pc)
    );

    evt_ctx_fsm #(.DW(DW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .evt_start (evt_start),
        .evt_code  (evt_code),
        .ret_start (ret_start),
        .sp_in     (sp_in),
        .sr_in     (sr_in),
        .pc_in     (pc_in),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .rf_rdata  (rf_rdata),
        .cur_item  (cur_item),
        .entry_sr  (entry_sr),
        .entry_pc  (entry_pc),
        .pos       (pos),
        .code_q    (code_q),
        .sr_q      (sr_q),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .rf_raddr  (rf_raddr),
        .rf_we     (rf_we),
        .rf_waddr  (rf_waddr),
        .rf_wdata  (rf_wdata),
        .sp_we     (sp_we),
        .sp_wdata  (sp_wdata),
        .sr_we     (sr_we),
        .sr_wdata  (sr_wdata),
        .pc_we     (pc_we),
        .pc_wdata  (pc_wdata)
    );
endmodule

// File: rtl/evt_ctx_chk.sv
module evt_ctx_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          evt_start,
    input logic          ret_start,
    input logic          busy,
    input logic          mem_req,
    input logic          mem_we,
    input logic [DW-1:0] mem_addr,
    input logic          mem_ack,
    input logic          rf_we,
    input logic          sr_we,
    input logic          pc_we,
    input logic          sp_we
);
    localparam logic [DW-1:0] WSTEP = DW'(DW / 8);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !rf_we && !sr_we));

    p_push_step_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && mem_we) |=> (!mem_req || (mem_we && mem_addr == $past(mem_addr) - WSTEP)));

    p_pop_step_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && !mem_we) |=> (!mem_req || (!mem_we && mem_addr == $past(mem_addr) + WSTEP)));

    p_rf_on_pop_r8: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (mem_req && mem_ack && !mem_we));

    p_start_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && (evt_start || ret_start)) |=> busy);

    p_busy_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(evt_start || ret_start));

    p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_fin_together_r12: assert property (@(posedge clk) disable iff (rst)
        (sr_we || pc_we || sp_we) |-> (sr_we && pc_we && sp_we && busy && !mem_req));

    p_fin_single_r12: assert property (@(posedge clk) disable iff (rst)
        sr_we |=> (!sr_we && !busy));
endmodule

bind evt_ctx_seq evt_ctx_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_evt_ctx_seq.sv
module sim_evt_ctx_seq;
    localparam int          DW     = 32;
    localparam logic [31:0] HBASE  = 32'h0000_4000;
    localparam logic [31:0] HSTEP  = 32'h0000_0080;
    localparam logic [31:0] BASE_SP = 32'h0000_0300;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst, evt_start, ret_start, busy;
    logic [2:0]  evt_code;
    logic        sp_we, sr_we, pc_we, rf_we, mem_req, mem_we, mem_ack;
    logic [31:0] sp_wdata, sr_wdata, pc_wdata, rf_wdata, rf_rdata, mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  rf_raddr, rf_waddr;
    logic [31:0] mem [256];
    logic [31:0] rf [16];
    logic [31:0] sr_b, pc_b, sp_b;
    int wr_cnt, wcnt, lat;
    int checks = 0;
    int errors = 0;

    assign rf_rdata = rf[rf_raddr];

    evt_ctx_seq #(.DW(DW), .HANDLER_BASE(HBASE), .HANDLER_STRIDE(HSTEP)) u0 (
        .clk(clk), .rst(rst), .evt_start(evt_start), .evt_code(evt_code), .ret_start(ret_start),
        .busy(busy), .sp_in(sp_b), .sr_in(sr_b), .pc_in(pc_b),
        .sp_we(sp_we), .sp_wdata(sp_wdata), .sr_we(sr_we), .sr_wdata(sr_wdata),
        .pc_we(pc_we), .pc_wdata(pc_wdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata));

    // Core state and memory model
    always @(posedge clk) begin
        if (rf_we) rf[rf_waddr] <= rf_wdata;
        if (sr_we) sr_b <= sr_wdata;
        if (pc_we) pc_b <= pc_wdata;
        if (sp_we) sp_b <= sp_wdata;
        if (rst) begin
            mem_ack <= 1'b0; wcnt <= 0; lat <= 0; wr_cnt <= 0; mem_rdata <= '0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem[mem_addr[9:2]];
                if (mem_we) begin
                    mem[mem_addr[9:2]] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end
                wcnt <= 0;
                lat  <= (lat + 1) % 3;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic logic [31:0] exp_sr(input logic [31:0] s, input int c);
        logic [31:0] r = s;
        r[2:0] = (c < 4) ? 3'(c + 2) : ((c == 4) ? 3'd6 : 3'd7);
        for (int i = 0; i < 4; i++) if (c >= 4 || i <= c) r[3 + i] = 1'b1;
        if (c >= 4) r[8] = 1'b1;
        if (c >= 5) r[7] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] exp_slot(input int k, input logic [31:0] s, input logic [31:0] p, input int c);
        if (k == 0) return s;
        if (k == 1) return p;
        if (k == 2) return 32'h5000_0000 + 32'(c * 256 + 14);
        return 32'h5000_0000 + 32'(c * 256 + 15 - k);
    endfunction

    task automatic wait_idle(input string req);
        int n = 0;
        while (busy && n < 2000) begin @(negedge clk); n++; end
        check(req, 32'(busy), 32'd0);
    endtask

    task automatic run_case(input int c, input logic [31:0] s, input logic [31:0] p, input bit inject, input bit both);
        int nw = (c < 4) ? 8 : 2;
        int w0;
        for (int i = 0; i < 16; i++) rf[i] <= 32'h5000_0000 + 32'(c * 256 + i);
        for (int i = 0; i < 256; i++) mem[i] <= 32'hDEAD_0000 + 32'(i);
        sr_b <= s; pc_b <= p; sp_b <= BASE_SP;
        @(negedge clk);
        w0 = wr_cnt;
        evt_start <= 1'b1; evt_code <= 3'(c); ret_start <= both;
        @(negedge clk);
        evt_start <= 1'b0; ret_start <= 1'b0;
        check("R9 busy after start", 32'(busy), 32'd1);
        if (inject) begin
            evt_start <= 1'b1; evt_code <= 3'(c ^ 1); ret_start <= 1'b1;
            @(negedge clk);
            evt_start <= 1'b0; ret_start <= 1'b0;
        end
        wait_idle("R9 entry ends");
        check(both ? "R11 entry wins sp" : "R6 entry sp", sp_b, BASE_SP - 32'(4 * nw));
        check(inject ? "R9 ignored start pc" : "R4 handler pc", pc_b, HBASE + 32'(c) * HSTEP);
        check("R5 new status", sr_b, exp_sr(s, c));
        for (int k = 0; k < nw; k++)
            check("R3 stack slot", mem[(BASE_SP - 32'(4 * (k + 1))) >> 2], exp_slot(k, s, p, c));
        check("R2 below stack untouched", mem[(BASE_SP - 32'(4 * (nw + 1))) >> 2],
              32'hDEAD_0000 + ((BASE_SP - 32'(4 * (nw + 1))) >> 2));
        check("R10 one word per ack", 32'(wr_cnt - w0), 32'(nw));
        // clobber registers and PC, then return
        for (int i = 8; i < 15; i++) rf[i] <= 32'hBAD0_0000 + 32'(i);
        pc_b <= 32'h0;
        @(negedge clk);
        ret_start <= 1'b1;
        @(negedge clk);
        ret_start <= 1'b0;
        check("R9 busy after return start", 32'(busy), 32'd1);
        wait_idle("R9 return ends");
        check("R6 return sp", sp_b, BASE_SP);
        check("R8 restored pc", pc_b, p);
        check("R8 restored status", sr_b, s);
        for (int i = 8; i < 15; i++) begin
            if (i == 13) continue;
            if (c < 4) check("R8 restored register", rf[i], 32'h5000_0000 + 32'(c * 256 + i));
            else       check("R7 short return keeps register", rf[i], 32'hBAD0_0000 + 32'(i));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'h0000_0000;
        pats[1] = 32'h1234_0049;
        pats[2] = 32'hFFFF_FE01;
        pats[3] = 32'h8000_0181;
        rst = 1'b1; evt_start = 1'b0; ret_start = 1'b0; evt_code = 3'd0;
        sr_b = '0; pc_b = '0; sp_b = BASE_SP;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy after reset", 32'(busy), 32'd0);
        check("R1 mem_req after reset", 32'(mem_req), 32'd0);
        check("R1 write strobes after reset", 32'({rf_we, sr_we, pc_we, sp_we}), 32'd0);
        for (int c = 0; c < 8; c++)
            for (int q = 0; q < 4; q++)
                run_case(c, pats[q], 32'h0001_0000 + 32'(c * 16 + q * 4), q == 1, 1'b0);
        run_case(2, 32'h0000_0011, 32'h0002_0000, 1'b0, 1'b1);
        run_case(6, 32'h0000_0001, 32'h0002_0040, 1'b0, 1'b1);
        summary();
    end
endmodule